// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers eight interrupt request lines, holds them in a request register, removes the masked lines, and picks a winner by fixed priority. Line 0 has the highest priority. It raises a single interrupt output to the host when a request can preempt the current service level. The host answers with a two-pulse acknowledge. The first pulse freezes the winner and marks it in service. The second pulse returns an 8-bit vector, built from a programmed base with the line number placed in its low three bits.

Software reaches the block through a small register port. The command address starts the setup sequence, issues end-of-interrupt commands, and chooses what command-address reads return. The data address takes the setup words and, after setup, the mask. A third address holds the per-line trigger-mode register.

Two controllers can be chained. A master marks in its cascade mask the inputs that have a slave attached, and puts the winning line number on the cascade outputs. A slave answers an acknowledge only when the cascade number it receives equals its programmed identity.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, no vector is valid, the mask reads 0xFF, the trigger register reads 0x00, the in-service register is clear, and command-address reads return the request register.
- R2: A command write (address 0) with bit 4 set starts setup. The following data writes (address 1) are taken as the vector base and then the cascade word. If bit 0 of that command was set, a third data write is taken as the mode word. Any later data write loads the mask. Starting setup clears the in-service register and the auto mode, and selects request readback.
- R3: Outside setup, a data write loads the mask, and a data read returns the last value written. A 1 bit masks its line.
- R4: Address 2 holds the trigger register, which reads back as written. Bit n = 0 makes line n edge-sensed and bit n = 1 makes it level-sensed.
- R5: An edge-sensed line sets its request bit on a rising input. The bit stays set after the input falls, and it is cleared when that line wins the first acknowledge pulse.
- R6: A level-sensed line's request bit follows the input, one clock later. It is not latched.
- R7: Outside an acknowledge sequence, the interrupt output is high exactly when some unmasked requested line has a lower index than every in-service line.
- R8: The first acknowledge pulse sets the in-service bit of the winning line. The cycle after the second pulse, vector-valid is high for one cycle with vector = {base[7:3], line}.
- R9: A command write of 0x60+n (n in 0..7) clears in-service bit n only.
- R10: A command write of 0x0A selects request readback and 0x0B selects in-service readback on command-address reads. The choice holds until it is changed again.
- R11: When mode word bit 1 is set, acknowledges leave the in-service register clear.
- R12: If no line qualifies at the first acknowledge pulse, the second pulse returns vector {base[7:3], 7} and no in-service bit is set.
- R13: On a master (is_master = 1), when the winning line's bit is set in the cascade word, cas_out carries the line number and cas_drive is high from the first acknowledge until the second. No vector is given.
- R14: On a slave (is_master = 0), acknowledges have an effect only when cas_in equals bits 2:0 of the cascade word. Otherwise no vector is given and no in-service bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, used with bus_sel |
| bus_addr | input | 2 | 0 command, 1 data/mask, 2 trigger |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| int_out | output | 1 | Interrupt request to the host |
| int_ack | input | 1 | Acknowledge pulse from the host |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec_out | output | 8 | Interrupt vector |
| cas_in | input | 3 | Cascade number seen by a slave |
| cas_out | output | 3 | Cascade number driven by a master |
| cas_drive | output | 1 | cas_out is valid |

## Verification
Single edge pulses show that requests are latched and then consumed by the acknowledge. Held and dropped level inputs show that a level line follows its input and can end in a spurious vector. Requests raised together and in a nested order separate plain priority from the in-service masking, and specific end-of-interrupt commands then show that only the named bit is released. Masked requests, the auto mode, a master with a cascaded line, and a slave given the wrong and then the right cascade number each exercise one of the alternate acknowledge paths.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int LINES = 8;
    localparam int IDW   = $clog2(LINES);
    localparam int DW    = 8;
    localparam int AW    = 2;

    localparam logic [AW-1:0] ADDR_CMD  = 2'd0;
    localparam logic [AW-1:0] ADDR_DATA = 2'd1;
    localparam logic [AW-1:0] ADDR_TRIG = 2'd2;

    typedef enum logic [1:0] {
        CFG_RUN,
        CFG_BASE,
        CFG_CASC,
        CFG_MODE
    } cfg_state_e;

    // Returns {found, index} of the lowest set bit (highest priority).
    function automatic logic [IDW:0] first_set(input logic [LINES-1:0] v);
        logic [IDW:0] r;
        r = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) r = {1'b1, IDW'(i)};
        end
        return r;
    endfunction
endpackage

// File: rtl/vic_cfg_port.sv
module vic_cfg_port
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [LINES-1:0]  mask,
    output logic [LINES-1:0]  trig,
    output logic [DW-1:0]     base,
    output logic [DW-1:0]     casc,
    output logic              auto_eoi,
    output logic              show_isr,
    output logic              eoi_stb,
    output logic [IDW-1:0]    eoi_line,
    output logic              init_stb
);
    typedef struct packed {
        cfg_state_e       state;
        logic             need_mode;
        logic [LINES-1:0] mask;
        logic [LINES-1:0] trig;
        logic [DW-1:0]    base;
        logic [DW-1:0]    casc;
        logic             auto_eoi;
        logic             show_isr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        eoi_stb  = 1'b0;
        init_stb = 1'b0;
        eoi_line = wdata[IDW-1:0];
        if (sel && wr) begin
            case (addr)
                ADDR_CMD: begin
                    if (wdata[4]) begin
                        cfg_d.state     = CFG_BASE;
                        cfg_d.need_mode = wdata[0];
                        cfg_d.auto_eoi  = 1'b0;
                        cfg_d.show_isr  = 1'b0;
                        init_stb        = 1'b1;
                    end else if (wdata[3]) begin
                        if (wdata[1]) cfg_d.show_isr = wdata[0];
                    end else if (wdata[7:5] == 3'b011) begin
                        eoi_stb = 1'b1;
                    end
                end
                ADDR_DATA: begin
                    case (cfg_q.state)
                        CFG_BASE: begin
                            cfg_d.base  = wdata;
                            cfg_d.state = CFG_CASC;
                        end
                        CFG_CASC: begin
                            cfg_d.casc  = wdata;
                            cfg_d.state = cfg_q.need_mode ? CFG_MODE : CFG_RUN;
                        end
                        CFG_MODE: begin
                            cfg_d.auto_eoi = wdata[1];
                            cfg_d.state    = CFG_RUN;
                        end
                        default: cfg_d.mask = wdata[LINES-1:0];
                    endcase
                end
                ADDR_TRIG: cfg_d.trig = wdata[LINES-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q           <= '0;
            cfg_q.state     <= CFG_RUN;
            cfg_q.mask      <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask     = cfg_q.mask;
    assign trig     = cfg_q.trig;
    assign base     = cfg_q.base;
    assign casc     = cfg_q.casc;
    assign auto_eoi = cfg_q.auto_eoi;
    assign show_isr = cfg_q.show_isr;
endmodule

// File: rtl/vic_req_latch.sv
module vic_req_latch
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] trig,
    input  logic [LINES-1:0] clr,
    output logic [LINES-1:0] irr
);
    typedef struct packed {
        logic [LINES-1:0] prev;
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] edg;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d.prev = irq_in;
        req_d.lvl  = irq_in;
        req_d.edg  = (req_q.edg | (irq_in & ~req_q.prev)) & ~clr & ~trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign irr[g] = trig[g] ? req_q.lvl[g] : req_q.edg[g];
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [LINES-1:0] irr,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] isr,
    output logic             int_req,
    output logic [IDW-1:0]   win_line
);
    logic [LINES-1:0] pending;
    logic [IDW:0]     pend_f;
    logic [IDW:0]     svc_f;

    always_comb begin
        pending  = irr & ~mask;
        pend_f   = first_set(pending);
        svc_f    = first_set(isr);
        win_line = pend_f[IDW-1:0];
        int_req  = pend_f[IDW] && (!svc_f[IDW] || (pend_f[IDW-1:0] < svc_f[IDW-1:0]));
    end
endmodule

// File: rtl/vectored_irq_ctrl.sv
module vectored_irq_ctrl
    import vic_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [1:0]     bus_addr,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    input  logic [7:0]     irq_in,
    input  logic           is_master,
    output logic           int_out,
    input  logic           int_ack,
    output logic           vec_valid,
    output logic [7:0]     vec_out,
    input  logic [2:0]     cas_in,
    output logic [2:0]     cas_out,
    output logic           cas_drive
);
    typedef struct packed {
        logic [LINES-1:0] isr;
        logic             phase;
        logic [IDW-1:0]   win;
        logic             vld;
        logic [DW-1:0]    vec;
        logic             cdrv;
        logic [IDW-1:0]   cid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LINES-1:0] mask_vec, trig_vec, irr_vec, isr_vec, clr_edge;
    logic [DW-1:0]    base_vec, casc_vec;
    logic             aeoi_w, show_isr, eoi_stb, init_stb, int_req, selected;
    logic [IDW-1:0]   eoi_line, win_line;

    vic_cfg_port u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .mask     (mask_vec),
        .trig     (trig_vec),
        .base     (base_vec),
        .casc     (casc_vec),
        .auto_eoi (aeoi_w),
        .show_isr (show_isr),
        .eoi_stb  (eoi_stb),
        .eoi_line (eoi_line),
        .init_stb (init_stb)
    );

    vic_req_latch u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .trig   (trig_vec),
        .clr    (clr_edge),
        .irr    (irr_vec)
    );

    vic_arbiter u_arb (
        .irr      (irr_vec),
        .mask     (mask_vec),
        .isr      (ctl_q.isr),
        .int_req  (int_req),
        .win_line (win_line)
    );

    assign isr_vec  = ctl_q.isr;
    assign selected = is_master || (cas_in == casc_vec[IDW-1:0]);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        clr_edge  = '0;
        if (init_stb) begin
            ctl_d.isr   = '0;
            ctl_d.phase = 1'b0;
            ctl_d.cdrv  = 1'b0;
        end else begin
            if (eoi_stb) ctl_d.isr[eoi_line] = 1'b0;
            if (int_ack && selected) begin
                if (!ctl_q.phase) begin
                    ctl_d.phase = 1'b1;
                    if (int_req) begin
                        ctl_d.win          = win_line;
                        clr_edge[win_line] = 1'b1;
                        if (!aeoi_w) ctl_d.isr[win_line] = 1'b1;
                        ctl_d.cdrv = is_master && casc_vec[win_line];
                        ctl_d.cid  = win_line;
                    end else begin
                        ctl_d.win  = IDW'(LINES - 1);
                        ctl_d.cdrv = 1'b0;
                    end
                end else begin
                    ctl_d.phase = 1'b0;
                    ctl_d.cdrv  = 1'b0;
                    if (!ctl_q.cdrv) begin
                        ctl_d.vld = 1'b1;
                        ctl_d.vec = {base_vec[DW-1:IDW], ctl_q.win};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CMD:  bus_rdata = show_isr ? ctl_q.isr : irr_vec;
            ADDR_DATA: bus_rdata = mask_vec;
            ADDR_TRIG: bus_rdata = trig_vec;
            default:   bus_rdata = '0;
        endcase
    end

    assign int_out   = int_req && !ctl_q.phase;
    assign vec_valid = ctl_q.vld;
    assign vec_out   = ctl_q.vec;
    assign cas_out   = ctl_q.cid;
    assign cas_drive = ctl_q.cdrv;
endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             int_ack,
    input logic             int_out,
    input logic             vec_valid,
    input logic [7:0]       vec_out,
    input logic             cas_drive,
    input logic             is_master,
    input logic [LINES-1:0] irr_vec,
    input logic [LINES-1:0] mask_vec,
    input logic [LINES-1:0] isr_vec,
    input logic [DW-1:0]    base_vec,
    input logic             aeoi_w,
    input logic             eoi_stb,
    input logic [IDW-1:0]   eoi_line
);
    a_r7_int_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(irr_vec & ~mask_vec));

    a_r8_vector_base: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[7:IDW] == base_vec[7:IDW]));

    a_r8_vector_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    a_r9_eoi_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && !int_ack) |=> !isr_vec[$past(eoi_line)]);

    a_r11_auto_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (aeoi_w && isr_vec == '0) |=> (isr_vec == '0));

    a_r13_cascade_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        cas_drive |-> is_master);

    a_r13_no_vector_when_cascaded: assert property (@(posedge clk) disable iff (!rst_n)
        cas_drive |-> !vec_valid);
endmodule

bind vectored_irq_ctrl vic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_ack   (int_ack),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .cas_drive (cas_drive),
    .is_master (is_master),
    .irr_vec   (irr_vec),
    .mask_vec  (mask_vec),
    .isr_vec   (isr_vec),
    .base_vec  (base_vec),
    .aeoi_w    (aeoi_w),
    .eoi_stb   (eoi_stb),
    .eoi_line  (eoi_line)
);

// File: tb/vectored_irq_ctrl_test.sv
`timescale 1ns/1ps
module vectored_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       is_master = 1'b1;
    logic       int_out, int_ack = 1'b0, vec_valid, cas_drive;
    logic [7:0] vec_out;
    logic [2:0] cas_in = 3'd0, cas_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vectored_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .is_master(is_master), .int_out(int_out),
        .int_ack(int_ack), .vec_valid(vec_valid), .vec_out(vec_out),
        .cas_in(cas_in), .cas_out(cas_out), .cas_drive(cas_drive)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ack(output logic vv, output logic [7:0] vo);
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        vv = vec_valid; vo = vec_out;
        int_ack = 1'b0;
    endtask

    task automatic setup(input logic [7:0] base, input logic [7:0] casc,
                         input logic with_mode, input logic [7:0] mode);
        wr(2'd0, with_mode ? 8'h11 : 8'h10);
        wr(2'd1, base);
        wr(2'd1, casc);
        if (with_mode) wr(2'd1, mode);
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic read_isr(output logic [7:0] d);
        wr(2'd0, 8'h0B);
        rd(2'd0, d);
        wr(2'd0, 8'h0A);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        rd(2'd1, d); chk("R1 mask", d, 8'hFF);
        rd(2'd2, d); chk("R1 trigger", d, 8'h00);
        rd(2'd0, d); chk("R1 request readback", d, 8'h00);
        wr(2'd0, 8'h0B); rd(2'd0, d); chk("R1 in-service", d, 8'h00);
        wr(2'd0, 8'h0A);
    endtask

    task automatic t_setup;
        logic [7:0] d;
        setup(8'h40, 8'h00, 1'b0, 8'h00);
        wr(2'd1, 8'h5A);
        rd(2'd1, d); chk("R2 short setup then mask", d, 8'h5A);
        setup(8'h20, 8'h00, 1'b1, 8'h01);
        rd(2'd1, d); chk("R2 mode word not mask", d, 8'h5A);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R2 mask after setup", d, 8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        wr(2'd1, 8'hA5); rd(2'd1, d); chk("R3 mask A5", d, 8'hA5);
        wr(2'd1, 8'h00); rd(2'd1, d); chk("R3 mask 00", d, 8'h00);
        wr(2'd2, 8'h3C); rd(2'd2, d); chk("R4 trigger 3C", d, 8'h3C);
        wr(2'd2, 8'h00); rd(2'd2, d); chk("R4 trigger 00", d, 8'h00);
    endtask

    task automatic t_edge;
        logic [7:0] d, vo;
        logic vv;
        set_irq(8'h08); set_irq(8'h00);
        chk("R5 int after pulse", {7'd0, int_out}, 8'h01);
        rd(2'd0, d); chk("R5 latched after fall", d, 8'h08);
        ack(vv, vo);
        rd(2'd0, d); chk("R5 cleared by ack", d, 8'h00);
        ack(vv, vo);
        chk("R8 vec_valid", {7'd0, vv}, 8'h01);
        chk("R8 vector line 3", vo, 8'h23);
        read_isr(d); chk("R8 in-service line 3", d, 8'h08);
        wr(2'd0, 8'h63);
        read_isr(d); chk("R9 eoi line 3", d, 8'h00);
    endtask

    task automatic t_level;
        logic [7:0] d;
        wr(2'd2, 8'h20);
        set_irq(8'h20);
        rd(2'd0, d); chk("R6 level high", d, 8'h20);
        chk("R6 int on level", {7'd0, int_out}, 8'h01);
        set_irq(8'h00);
        rd(2'd0, d); chk("R6 level dropped", d, 8'h00);
        chk("R6 int drops", {7'd0, int_out}, 8'h00);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_priority;
        logic [7:0] d, vo;
        logic vv;
        set_irq(8'h50); set_irq(8'h00);
        ack(vv, vo); ack(vv, vo);
        chk("R8 line 4 beats 6", vo, 8'h24);
        chk("R7 line 6 blocked by 4", {7'd0, int_out}, 8'h00);
        set_irq(8'h02); set_irq(8'h00);
        chk("R7 line 1 nests over 4", {7'd0, int_out}, 8'h01);
        ack(vv, vo); ack(vv, vo);
        chk("R8 nested vector", vo, 8'h21);
        read_isr(d); chk("R8 nested in-service", d, 8'h12);
        wr(2'd0, 8'h61);
        read_isr(d); chk("R9 only line 1 cleared", d, 8'h10);
        wr(2'd0, 8'h64);
        chk("R7 line 6 released", {7'd0, int_out}, 8'h01);
        ack(vv, vo); ack(vv, vo);
        chk("R8 vector line 6", vo, 8'h26);
        wr(2'd0, 8'h66);
        wr(2'd1, 8'h08);
        set_irq(8'h08); set_irq(8'h00);
        chk("R7 masked no int", {7'd0, int_out}, 8'h00);
        rd(2'd0, d); chk("R10 masked line in request readback", d, 8'h08);
        wr(2'd1, 8'h00);
        chk("R7 unmasked int", {7'd0, int_out}, 8'h01);
        ack(vv, vo); ack(vv, vo);
        chk("R8 vector after unmask", vo, 8'h23);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R10 isr select", d, 8'h08);
        wr(2'd1, 8'h00);
        rd(2'd0, d); chk("R10 isr select persists", d, 8'h08);
        wr(2'd0, 8'h0A);
        rd(2'd0, d); chk("R10 request select", d, 8'h00);
        wr(2'd0, 8'h63);
    endtask

    task automatic t_spurious;
        logic [7:0] d, vo;
        logic vv;
        wr(2'd2, 8'h20);
        set_irq(8'h20);
        set_irq(8'h00);
        ack(vv, vo); ack(vv, vo);
        chk("R12 spurious valid", {7'd0, vv}, 8'h01);
        chk("R12 spurious vector", vo, 8'h27);
        read_isr(d); chk("R12 no service entry", d, 8'h00);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_auto;
        logic [7:0] d, vo;
        logic vv;
        setup(8'h20, 8'h00, 1'b1, 8'h03);
        wr(2'd1, 8'h00);
        set_irq(8'h04); set_irq(8'h00);
        ack(vv, vo); ack(vv, vo);
        chk("R11 auto vector", vo, 8'h22);
        read_isr(d); chk("R11 in-service stays clear", d, 8'h00);
        setup(8'h20, 8'h04, 1'b1, 8'h01);
    endtask

    task automatic t_cascade;
        logic [7:0] d, vo;
        logic vv;
        set_irq(8'h04); set_irq(8'h00);
        ack(vv, vo);
        chk("R13 cas_drive", {7'd0, cas_drive}, 8'h01);
        chk("R13 cas_out", {5'd0, cas_out}, 8'h02);
        ack(vv, vo);
        chk("R13 no vector", {7'd0, vv}, 8'h00);
        chk("R13 cas released", {7'd0, cas_drive}, 8'h00);
        read_isr(d); chk("R13 in-service line 2", d, 8'h04);
        wr(2'd0, 8'h62);
    endtask

    task automatic t_slave;
        logic [7:0] d, vo;
        logic vv;
        is_master = 1'b0;
        setup(8'h70, 8'h02, 1'b1, 8'h01);
        wr(2'd1, 8'h00);
        set_irq(8'h01); set_irq(8'h00);
        cas_in = 3'd5;
        ack(vv, vo); ack(vv, vo);
        chk("R14 other id no vector", {7'd0, vv}, 8'h00);
        chk("R14 other id int stays", {7'd0, int_out}, 8'h01);
        read_isr(d); chk("R14 other id no service", d, 8'h00);
        cas_in = 3'd2;
        ack(vv, vo); ack(vv, vo);
        chk("R14 own id vector", vo, 8'h70);
        read_isr(d); chk("R14 own id service", d, 8'h01);
        wr(2'd0, 8'h60);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setup();
        t_mask();
        t_edge();
        t_level();
        t_priority();
        t_spurious();
        t_auto();
        t_cascade();
        t_slave();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule